// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Generator Mode

This block is a 16-bit up-counting timer peripheral for a microcontroller subsystem. One control byte selects how it behaves. It can count internal tick pulses or falling edges on an external count pin. A second external pin, the trigger, can either snapshot the running count into a 16-bit capture/reload register or force the count back to that register's value. The block also has a baud-rate generator mode. In that mode it advances every second clock, reloads on every overflow, and drives the receive and transmit clock-source selects of a serial port.

Software reaches every register through a byte-wide read/write bus with combinational read data. The block raises an interrupt request while either of its two sticky flags is set. It also gives a one-cycle pulse on each count wrap.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 00h and the outputs irq, ovf_pulse, rx_clk_sel and tx_clk_sel are all 0.
- R2: The control byte sits at address C8h. Its bits, from 7 down to 0, are: overflow flag, trigger flag, receive-clock select, transmit-clock select, trigger enable, run, external-count select and capture select. The capture/reload register sits at CAh (low byte) and CBh (high byte). The count sits at CCh (low byte) and CDh (high byte). All five addresses read back what was written. Any other address reads 00h.
- R3: With run=1, external-count select=0 and neither clock select set, the count advances by one on each cycle in which tick_en is 1. With external-count select=1, tick_en is ignored and each falling edge of cnt_pin advances the count by one. That update lands on the third rising edge, counting from the first edge that samples the pin low. The trigger pin has the same latency.
- R4: With run=0, the count holds its value while ticks and count-pin edges arrive.
- R5: Outside baud mode, a step taken at FFFFh sets the overflow flag (bit 7). In the clock cycle after that edge, ovf_pulse is 1 for exactly one cycle.
- R6: With capture select=0 outside baud mode, an overflow loads the count from the capture/reload register. A trigger falling edge with trigger enable=1 also loads the count from that register and sets the trigger flag.
- R7: With capture select=1 outside baud mode, a trigger falling edge with trigger enable=1 copies the count into the capture/reload register and sets the trigger flag, and the count keeps its value. In this mode an overflow wraps the count to 0000h.
- R8: With trigger enable=0, a trigger falling edge changes neither the flags, nor the count, nor the capture/reload register.
- R9: Either clock select (bit 5 or bit 4) set means baud mode. rx_clk_sel follows bit 5 and tx_clk_sel follows bit 4. In baud mode the count advances every second clock while run=1, regardless of tick_en and external-count select. Every overflow reloads the count, capture select is ignored, and the overflow flag is not set. A trigger edge with enable=1 sets the trigger flag but causes no reload.
- R10: Hardware never clears either flag. Software writes can set or clear both flags. irq is 1 whenever either flag is 1.
- R11: When hardware sets a flag in the same cycle that software writes the control byte, the flag ends up set. When a capture lands in the same cycle as a software write to a capture/reload byte, the captured value wins.
- R12: A software write to a count byte loads that byte, leaves the other byte unchanged, and suppresses any count step or reload in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal tick pulse (one cycle in twelve) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger pin, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle pulse after each count wrap |
| rx_clk_sel | output | 1 | Receive clock source select |
| tx_clk_sel | output | 1 | Transmit clock source select |

## Verification
The two collisions that matter are a hardware flag set landing on the same edge as a software control write, and a trigger capture landing on the same edge as a software write to the capture/reload low byte. The first is provoked by raising tick_en with the count at FFFFh in the very cycle that a write clears the overflow flag; the control byte must then still show the flag set. The second is provoked by dropping the trigger pin and starting a capture-byte write two falling clock edges later, which puts the write on the third rising edge, where the capture takes place. The register must then hold the captured count and not the written byte.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam int BYTE_W = 8;

  // Control byte layout, most significant bit first.
  typedef struct packed {
    logic tf;       // overflow flag
    logic exf;      // trigger flag
    logic rxsel;    // receive clock select
    logic txsel;    // transmit clock select
    logic exen;     // trigger pin enable
    logic run;      // counting enable
    logic ext_cnt;  // count external pin edges
    logic capt;     // capture on trigger instead of reload
  } tmr_ctrl_t;

  function automatic logic is_baud(input tmr_ctrl_t c);
    return c.rxsel | c.txsel;
  endfunction

  function automatic logic is_irq(input tmr_ctrl_t c);
    return c.tf | c.exf;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  // Flops preset high so an idle-high pin gives no edge out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];

endmodule

// File: rtl/tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              set_tf,
  input  logic              set_exf,
  output tmr_ctrl_t         ctrl
);

  tmr_ctrl_t ctrl_nx;

  // Software write first, then hardware sets on top so they win.
  always_comb begin
    ctrl_nx = ctrl;
    if (wr_en)   ctrl_nx = tmr_ctrl_t'(wdata);
    if (set_tf)  ctrl_nx.tf  = 1'b1;
    if (set_exf) ctrl_nx.exf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nx;
  end

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter  int CNT_BYTES = 2,
  localparam int CNT_W     = CNT_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_baud,
  input  logic                 run,
  input  logic                 ext_cnt,
  input  logic                 capt,
  input  logic                 exen,
  input  logic                 tick_en,
  input  logic                 cnt_fall,
  input  logic                 trig_fall,
  input  logic [CNT_BYTES-1:0] wr_cnt_b,
  input  logic [CNT_BYTES-1:0] wr_rcap_b,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     rcap,
  output logic                 ovf_pulse,
  output logic                 inc_evt,
  output logic                 ovf_evt,
  output logic                 cap_evt,
  output logic                 ext_evt
);

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic             half_q;
  logic             step;
  logic             cnt_wr;
  logic             rld_evt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] rcap_nx;

  // Divide-by-two pacing used only while generating baud clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                half_q <= 1'b0;
    else if (mode_baud && run) half_q <= ~half_q;
    else                       half_q <= 1'b0;
  end

  assign cnt_wr  = |wr_cnt_b;
  assign step    = mode_baud ? (run & half_q)
                             : (run & (ext_cnt ? cnt_fall : tick_en));
  assign inc_evt = step & ~cnt_wr;
  assign ovf_evt = inc_evt & at_top(count);
  assign ext_evt = exen & trig_fall;
  assign cap_evt = ext_evt & ~mode_baud & capt;
  assign rld_evt = ~cnt_wr & ((ovf_evt & (mode_baud | ~capt))
                            | (ext_evt & ~mode_baud & ~capt));

  always_comb begin
    cnt_nx = count;
    if (rld_evt)      cnt_nx = rcap;
    else if (inc_evt) cnt_nx = bump(count);
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (wr_cnt_b[b]) cnt_nx[b*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_comb begin
    rcap_nx = rcap;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (cap_evt)           rcap_nx[b*BYTE_W +: BYTE_W] = count[b*BYTE_W +: BYTE_W];
      else if (wr_rcap_b[b]) rcap_nx[b*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      rcap      <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      count     <= cnt_nx;
      rcap      <= rcap_nx;
      ovf_pulse <= ovf_evt;
    end
  end

endmodule

// File: rtl/cap_reload_timer.sv
`timescale 1ns/1ps
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter  int                CNT_BYTES   = 2,
  parameter  int                ADDR_W      = 8,
  parameter  logic [ADDR_W-1:0] ADDR_CTRL   = 'hC8,
  parameter  logic [ADDR_W-1:0] ADDR_RCAP   = 'hCA,
  parameter  logic [ADDR_W-1:0] ADDR_CNT    = 'hCC,
  parameter  int                SYNC_STAGES = 2,
  localparam int                CNT_W       = CNT_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              ovf_pulse,
  output logic              rx_clk_sel,
  output logic              tx_clk_sel
);

  localparam int NPINS = 2;

  tmr_ctrl_t            ctrl_q;
  logic                 mode_baud;
  logic                 wr_ctrl;
  logic [CNT_BYTES-1:0] wr_cnt_b;
  logic [CNT_BYTES-1:0] wr_rcap_b;
  logic                 cnt_wr_any;
  logic [NPINS-1:0]     pin_vec;
  logic [NPINS-1:0]     fall_vec;
  logic                 trig_fall;
  logic                 cnt_fall;
  logic [CNT_W-1:0]     count_w;
  logic [CNT_W-1:0]     rcap_w;
  logic                 inc_evt;
  logic                 ovf_evt;
  logic                 cap_evt;
  logic                 ext_evt;
  logic                 set_tf;

  // Address decode, one strobe per byte lane.
  assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
    assign wr_rcap_b[b] = bus_wr & (bus_addr == ADDR_W'(int'(ADDR_RCAP) + b));
    assign wr_cnt_b[b]  = bus_wr & (bus_addr == ADDR_W'(int'(ADDR_CNT) + b));
  end

  assign cnt_wr_any = |wr_cnt_b;

  // Pin synchronizers: index 0 trigger, index 1 count.
  assign pin_vec = {cnt_pin, trig_pin};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_vec[p]),
      .fall (fall_vec[p])
    );
  end

  assign trig_fall = fall_vec[0];
  assign cnt_fall  = fall_vec[1];

  assign mode_baud = is_baud(ctrl_q);
  assign set_tf    = ovf_evt & ~mode_baud;

  tmr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .set_tf (set_tf),
    .set_exf(ext_evt),
    .ctrl   (ctrl_q)
  );

  tmr_count_core #(.CNT_BYTES(CNT_BYTES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_baud(mode_baud),
    .run      (ctrl_q.run),
    .ext_cnt  (ctrl_q.ext_cnt),
    .capt     (ctrl_q.capt),
    .exen     (ctrl_q.exen),
    .tick_en  (tick_en),
    .cnt_fall (cnt_fall),
    .trig_fall(trig_fall),
    .wr_cnt_b (wr_cnt_b),
    .wr_rcap_b(wr_rcap_b),
    .wdata    (bus_wdata),
    .count    (count_w),
    .rcap     (rcap_w),
    .ovf_pulse(ovf_pulse),
    .inc_evt  (inc_evt),
    .ovf_evt  (ovf_evt),
    .cap_evt  (cap_evt),
    .ext_evt  (ext_evt)
  );

  // Combinational read mux; unmapped addresses return zero.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_q;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (bus_addr == ADDR_W'(int'(ADDR_RCAP) + b)) bus_rdata = rcap_w[b*BYTE_W +: BYTE_W];
      if (bus_addr == ADDR_W'(int'(ADDR_CNT) + b))  bus_rdata = count_w[b*BYTE_W +: BYTE_W];
    end
  end

  assign irq        = is_irq(ctrl_q);
  assign rx_clk_sel = ctrl_q.rxsel;
  assign tx_clk_sel = ctrl_q.txsel;

endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tf,
  input logic             exf,
  input logic             rxsel,
  input logic             txsel,
  input logic             exen,
  input logic             run,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rcap,
  input logic             inc_evt,
  input logic             ovf_evt,
  input logic             cap_evt,
  input logic             trig_fall,
  input logic             ovf_pulse
);

  logic baud;
  assign baud = rxsel | txsel;

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !trig_fall) |=> $stable(count)); // R4

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_pulse); // R5

  AST_TF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !baud) |=> tf); // R5

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rcap == $past(count))); // R7

  AST_EXEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && !exen && !ctrl_wr) |=> (exf == $past(exf))); // R8

  AST_BAUD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && baud) |=> (count == $past(rcap))); // R9

  AST_BAUD_NO_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && baud && !ctrl_wr) |=> (tf == $past(tf))); // R9

  AST_BAUD_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && baud && !ctrl_wr) |=> !inc_evt); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tf && !ctrl_wr) |=> tf); // R10

endmodule

bind cap_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tf       (ctrl_q.tf),
  .exf      (ctrl_q.exf),
  .rxsel    (ctrl_q.rxsel),
  .txsel    (ctrl_q.txsel),
  .exen     (ctrl_q.exen),
  .run      (ctrl_q.run),
  .ctrl_wr  (wr_ctrl),
  .cnt_wr   (cnt_wr_any),
  .count    (count_w),
  .rcap     (rcap_w),
  .inc_evt  (inc_evt),
  .ovf_evt  (ovf_evt),
  .cap_evt  (cap_evt),
  .trig_fall(trig_fall),
  .ovf_pulse(ovf_pulse)
);

// File: tb/sim_cap_reload_timer.sv
`timescale 1ns/1ps
module sim_cap_reload_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, ovf_pulse, rx_clk_sel, tx_clk_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ovf_pulse(ovf_pulse), .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel)
  );

  localparam logic [7:0] A_CTL = 8'hC8, A_RLO = 8'hCA, A_RHI = 8'hCB,
                         A_CLO = 8'hCC, A_CHI = 8'hCD;

  // {write, addr, data, expected read, expected irq}
  localparam int NV = 23;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'hC8, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hCA, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hCB, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hCC, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hCD, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hCA, 8'h34, 8'h00, 1'b0},
    {1'b1, 8'hCB, 8'h12, 8'h00, 1'b0},
    {1'b0, 8'hCA, 8'h00, 8'h34, 1'b0},
    {1'b0, 8'hCB, 8'h00, 8'h12, 1'b0},
    {1'b1, 8'hCC, 8'h78, 8'h00, 1'b0},
    {1'b1, 8'hCD, 8'h56, 8'h00, 1'b0},
    {1'b0, 8'hCC, 8'h00, 8'h78, 1'b0},
    {1'b0, 8'hCD, 8'h00, 8'h56, 1'b0},
    {1'b0, 8'hC9, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hCE, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hC8, 8'h80, 8'h00, 1'b0},
    {1'b0, 8'hC8, 8'h00, 8'h80, 1'b1},
    {1'b1, 8'hC8, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hC8, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hC8, 8'h40, 8'h00, 1'b0},
    {1'b0, 8'hC8, 8'h00, 8'h40, 1'b1},
    {1'b1, 8'hC8, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hC8, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(A_CHI, h);
    rd(A_CLO, l);
    v = {h, l};
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] lo_a, input logic [15:0] v);
    wr(lo_a, v[7:0]);
    wr(lo_a + 8'd1, v[15:8]);
  endtask

  task automatic tick;
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c, c0;

    settle(3);
    // R1: outputs in reset and just after release
    chk("R1 irq", irq, 0);
    chk("R1 ovf_pulse", ovf_pulse, 0);
    chk("R1 clock selects", {rx_clk_sel, tx_clk_sel}, 0);
    rst_n = 1'b1;
    settle(1);

    // Register table (R1 reset reads, R2 map, R10 software flag access, R12 count bytes)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) wr(VEC[i][24:17], VEC[i][16:9]);
      else begin
        @(negedge clk);
        rd(VEC[i][24:17], d);
        chk("R2 table read", d, VEC[i][8:1]);
        chk("R10 table irq", irq, VEC[i][0]);
      end
    end

    // R3 / R5 / R6: tick counting, wrap, reload on overflow
    wr16(A_CLO, 16'hFFFE);
    wr(A_CTL, 8'h04);
    tick();
    rd16(c); chk("R3 tick count", c, 16'hFFFF);
    chk("R5 no pulse before wrap", ovf_pulse, 0);
    tick();
    rd16(c); chk("R6 reload on overflow", c, 16'h1234);
    chk("R5 ovf_pulse", ovf_pulse, 1);
    rd(A_CTL, d); chk("R5 overflow flag", d, 8'h84);
    chk("R10 irq from overflow flag", irq, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", ovf_pulse, 0);

    // R4 stop holds count; R10 flag persists
    wr(A_CTL, 8'h80);
    tick(); settle(3);
    rd16(c); chk("R4 stopped count", c, 16'h1234);
    rd(A_CTL, d); chk("R10 flag not cleared by hardware", d, 8'h80);
    wr(A_CTL, 8'h00);
    chk("R10 software clear", irq, 0);

    // R3 counter mode: ticks ignored, pin edges counted with latency
    wr(A_CTL, 8'h06);
    tick();
    rd16(c); chk("R3 tick ignored in counter mode", c, 16'h1234);
    @(negedge clk); cnt_pin = 1'b0;
    settle(2);
    rd16(c); chk("R3 count latency", c, 16'h1234);
    @(negedge clk);
    rd16(c); chk("R3 pin edge counted", c, 16'h1235);
    cnt_pin = 1'b1;
    settle(4);
    rd16(c); chk("R3 rising edge not counted", c, 16'h1235);

    // R8 trigger disabled
    wr(A_CTL, 8'h04);
    @(negedge clk); trig_pin = 1'b0;
    settle(4);
    rd(A_RLO, d); chk("R8 capture reg lo", d, 8'h34);
    rd(A_CTL, d); chk("R8 no trigger flag", d, 8'h04);
    rd16(c); chk("R8 count untouched", c, 16'h1235);
    trig_pin = 1'b1; settle(4);

    // R7 capture
    wr(A_CTL, 8'h0D);
    @(negedge clk); trig_pin = 1'b0;
    settle(4);
    rd(A_RLO, d); chk("R7 captured lo", d, 8'h35);
    rd(A_RHI, d); chk("R7 captured hi", d, 8'h12);
    rd(A_CTL, d); chk("R7 trigger flag", d, 8'h4D);
    @(negedge clk);
    rd16(c); chk("R7 count keeps running value", c, 16'h1235);
    trig_pin = 1'b1; settle(4);
    wr(A_CTL, 8'h0D);
    wr16(A_CLO, 16'hFFFF);
    tick();
    rd16(c); chk("R7 wrap to zero", c, 16'h0000);
    rd(A_CTL, d); chk("R7 overflow flag in capture mode", d, 8'h8D);
    wr(A_CTL, 8'h00);

    // R6 reload by trigger
    wr(A_CTL, 8'h0C);
    @(negedge clk); trig_pin = 1'b0;
    settle(4);
    rd16(c); chk("R6 trigger reload", c, 16'h1235);
    rd(A_CTL, d); chk("R6 trigger flag", d, 8'h4C);
    trig_pin = 1'b1; settle(4);
    wr(A_CTL, 8'h00);

    // R9 baud mode
    wr16(A_RLO, 16'hABCD);
    wr16(A_CLO, 16'hFFFE);
    wr(A_CTL, 8'h27);
    chk("R9 rx select", {rx_clk_sel, tx_clk_sel}, 2'b10);
    settle(2);
    rd16(c); chk("R9 half-rate step", c, 16'hFFFF);
    settle(2);
    rd16(c); chk("R9 reload on overflow", c, 16'hABCD);
    chk("R9 ovf_pulse", ovf_pulse, 1);
    rd(A_CTL, d); chk("R9 no overflow flag", d, 8'h27);
    wr(A_CTL, 8'h28);
    rd16(c0);
    @(negedge clk); trig_pin = 1'b0;
    settle(4);
    rd16(c); chk("R9 trigger causes no reload", c, c0);
    rd(A_CTL, d); chk("R9 trigger flag in baud", d, 8'h68);
    trig_pin = 1'b1; settle(4);
    wr(A_CTL, 8'h10);
    chk("R9 tx select", {rx_clk_sel, tx_clk_sel}, 2'b01);
    wr(A_CTL, 8'h00);

    // R11 overflow set versus same-cycle software clear
    wr16(A_RLO, 16'h0000);
    wr16(A_CLO, 16'hFFFF);
    wr(A_CTL, 8'h84);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_CTL; bus_wdata = 8'h04; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd(A_CTL, d); chk("R11 hardware set wins", d, 8'h84);
    rd16(c); chk("R11 count after collision", c, 16'h0000);
    wr(A_CTL, 8'h00);

    // R11 capture versus same-cycle capture-byte write
    wr16(A_CLO, 16'h4321);
    wr(A_CTL, 8'h09);
    @(negedge clk); trig_pin = 1'b0;
    settle(2);
    bus_addr = A_RLO; bus_wdata = 8'h99; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_RLO, d); chk("R11 capture beats write lo", d, 8'h21);
    rd(A_RHI, d); chk("R11 capture hi", d, 8'h43);
    rd(A_CTL, d); chk("R11 trigger flag", d, 8'h49);
    trig_pin = 1'b1; settle(4);

    // R12 count write suppresses stepping in its cycle
    wr(A_CTL, 8'h04);
    wr16(A_CLO, 16'h0100);
    @(negedge clk); tick_en = 1'b1;
    wr(A_CLO, 8'h11);
    rd16(c);
    tick_en = 1'b0;
    chk("R12 byte write, no step", c, 16'h0111);
    settle(2);
    rd16(c); chk("R12 value held after", c, 16'h0111);

    done = 1;
    summary();
    $finish;
  end

endmodule